// File: doc/BRIEF.md
# Byte-Wide to Double-Data-Rate Nibble Ethernet Bridge

This block joins a byte-wide, single-data-rate Ethernet datapath inside the chip to a reduced-pin gigabit PHY link. Each direction of that link has four data lines and one control line that are sampled on both clock edges. The bridge does not instantiate the I/O cells. On each side of the line, a pair of half-cycle values (the "rise" and "fall" halves) is handed to or taken from an external double-data-rate register. The rise half is the value for the rising clock edge and the fall half is the value for the falling edge. Both directions run on one clock, so any alignment of the receive clock is assumed to be done outside the bridge.

On transmit, the block takes bytes through a valid/ready stream. Each byte carries an error flag. The block drives a data nibble in each half-cycle and folds the enable and error flags onto the single control line. On receive, it unfolds the control line into a data-valid and an error flag and rebuilds bytes. At 1000 Mbit/s a whole byte crosses the link in each clock. At 100 and 10 Mbit/s only one nibble per clock is significant, so a byte takes two clocks, with the low nibble first.

Back-pressure rules:
- The transmit stream has back-pressure. A byte is taken at a clock edge only when `tx_valid` and `tx_ready` are both high.
- The upstream source must keep `tx_valid` high for the whole frame. A gap ends the frame on the wire.
- The receive stream has no ready signal, because a PHY cannot be stalled. The sink must accept every `rx_valid` pulse.

The line rate comes from `speed_sel`. The new rate takes effect only at a clock edge where neither direction has a frame in progress.

Top module: `gmii_rgmii_bridge`

## Requirements
- R1: In reset and right after it:
  - every transmit line half is 0 and `rx_valid` is 0;
  - the rate is 1000 Mbit/s, so `tx_ready` is 1.
- R2: At 1000 Mbit/s, a byte accepted at a clock edge appears right after that edge, with bits 3:0 on `rgmii_txd_rise` and bits 7:4 on `rgmii_txd_fall`.
- R3: The transmit control halves are encoded as follows:
  - the rise half is the enable;
  - the fall half is enable XOR error, so 1/1 is good data, 1/0 is an errored byte and 0/0 is idle;
  - the bridge never drives 0/1.
- R4: At 1000 Mbit/s, `tx_ready` is always 1.
- R5: At 10/100 Mbit/s, an accepted byte occupies two clocks:
  - the low nibble is driven on both halves in the first clock and the high nibble on both halves in the second;
  - both clocks carry the same control halves;
  - `tx_ready` is 0 during the second clock.
- R6: At 1000 Mbit/s, when the received control rise half is 1 at an edge, `rx_valid` is 1 right after that edge, with `rx_data` = {fall nibble, rise nibble}. When the rise half is 0, no byte is produced.
- R7: Received error flags are handled as follows:
  - a nibble's error flag is the XOR of its two control halves;
  - `rx_err` is 1 only together with `rx_valid`;
  - a control pattern of 0/1 produces no output.
- R8: At 10/100 Mbit/s, two consecutive received nibbles with the valid half set form one byte, the first being bits 3:0. `rx_valid` pulses right after the edge that takes the second nibble, and `rx_err` is the OR of both nibble errors.
- R9: If received data-valid drops after an odd number of nibbles, the unpaired nibble is discarded. The next frame starts again from a low nibble.
- R10: `speed_sel` (00 = 10, 01 = 100, 1x = 1000 Mbit/s) is taken only at an edge where all of the following hold:
  - `tx_valid` is 0;
  - no transmit high nibble is pending;
  - the received control rise half is 0;
  - no received nibble is pending.
  At any other edge it is ignored.
- R11: The bridge behaves the same at 10 and at 100 Mbit/s; only the clock rate differs.
- R12: Transmit and receive run independently and may both move data in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock shared by both directions |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_sel | input | 2 | Requested line rate: 00 = 10, 01 = 100, 1x = 1000 Mbit/s |
| tx_valid | input | 1 | Transmit byte valid; doubles as the frame enable |
| tx_ready | output | 1 | Bridge can take a transmit byte this clock |
| tx_data | input | 8 | Transmit byte |
| tx_err | input | 1 | Transmit byte is to be flagged as errored |
| rgmii_txd_rise | output | 4 | Transmit nibble for the rising half-cycle |
| rgmii_txd_fall | output | 4 | Transmit nibble for the falling half-cycle |
| rgmii_txctl_rise | output | 1 | Transmit control, rising half (enable) |
| rgmii_txctl_fall | output | 1 | Transmit control, falling half (enable XOR error) |
| rgmii_rxd_rise | input | 4 | Received nibble captured on the rising edge |
| rgmii_rxd_fall | input | 4 | Received nibble captured on the falling edge |
| rgmii_rxctl_rise | input | 1 | Received control, rising half (data valid) |
| rgmii_rxctl_fall | input | 1 | Received control, falling half (valid XOR error) |
| rx_valid | output | 1 | Rebuilt receive byte valid (one-clock pulse) |
| rx_data | output | 8 | Rebuilt receive byte |
| rx_err | output | 1 | Rebuilt receive byte carried an error |

## Verification
Two pairs of events can fall in the same clock.

- **A transmit nibble launch and a receive byte completion.** Random traffic drives both directions at every clock. So at 10/100 Mbit/s the second half of an outgoing byte often lands on the same edge as the second nibble of an incoming byte.
- **A rate request and frame activity.** A request in `speed_sel` can coincide with the frame activity that must block it. Directed runs hold `tx_valid` high while requesting a new rate, and random runs change `speed_sel` between frames.

Every clock is judged against a cycle model in the bench that is built only from the requirements. That model predicts `tx_ready`, both line halves and the rebuilt byte, so a rate switch applied one clock early or late shows up as a mismatch in the ready pattern or in the nibble order.

// File: rtl/gmii_rgmii_pkg.sv
package gmii_rgmii_pkg;

  // Line rate code carried on speed_sel; both upper codes mean gigabit.
  typedef enum logic [1:0] {
    SPD_10       = 2'b00,
    SPD_100      = 2'b01,
    SPD_1000     = 2'b10,
    SPD_1000_ALT = 2'b11
  } speed_e;

  // True when only one nibble per clock is significant on the line.
  function automatic logic speed_is_nibble(input speed_e s);
    return (s == SPD_10) || (s == SPD_100);
  endfunction

endpackage

// File: rtl/rgmii_speed_ctl.sv
module rgmii_speed_ctl
  import gmii_rgmii_pkg::*;
#(
  parameter speed_e RESET_SPEED = SPD_1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] speed_sel,
  input  logic       link_idle,
  output logic       nibble_mode
);

  speed_e speed_q;

  // The requested rate is only adopted on an edge where no frame moves.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed_q <= RESET_SPEED;
    end else if (link_idle) begin
      speed_q <= speed_e'(speed_sel);
    end
  end

  assign nibble_mode = speed_is_nibble(speed_q);

endmodule

// File: rtl/rgmii_tx_path.sv
module rgmii_tx_path #(
  parameter int BYTE_W = 8,
  localparam int NIB_W = BYTE_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nibble_mode,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_err,
  output logic              hi_pending,
  output logic [NIB_W-1:0]  txd_rise,
  output logic [NIB_W-1:0]  txd_fall,
  output logic              txctl_rise,
  output logic              txctl_fall
);

  logic             phase_q;
  logic [NIB_W-1:0] hi_q;
  logic             err_q;

  // In nibble mode the second clock of a byte cannot take a new one.
  always_comb begin
    tx_ready   = nibble_mode ? !phase_q : 1'b1;
    hi_pending = phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= 1'b0;
      hi_q       <= '0;
      err_q      <= 1'b0;
      txd_rise   <= '0;
      txd_fall   <= '0;
      txctl_rise <= 1'b0;
      txctl_fall <= 1'b0;
    end else if (!nibble_mode) begin
      phase_q <= 1'b0;
      if (tx_valid) begin
        txd_rise   <= tx_data[NIB_W-1:0];
        txd_fall   <= tx_data[BYTE_W-1:NIB_W];
        txctl_rise <= 1'b1;
        txctl_fall <= ~tx_err;
      end else begin
        txd_rise   <= '0;
        txd_fall   <= '0;
        txctl_rise <= 1'b0;
        txctl_fall <= 1'b0;
      end
    end else if (phase_q) begin
      // Second clock: upper nibble repeated on both halves.
      phase_q    <= 1'b0;
      txd_rise   <= hi_q;
      txd_fall   <= hi_q;
      txctl_rise <= 1'b1;
      txctl_fall <= ~err_q;
    end else if (tx_valid) begin
      phase_q    <= 1'b1;
      hi_q       <= tx_data[BYTE_W-1:NIB_W];
      err_q      <= tx_err;
      txd_rise   <= tx_data[NIB_W-1:0];
      txd_fall   <= tx_data[NIB_W-1:0];
      txctl_rise <= 1'b1;
      txctl_fall <= ~tx_err;
    end else begin
      txd_rise   <= '0;
      txd_fall   <= '0;
      txctl_rise <= 1'b0;
      txctl_fall <= 1'b0;
    end
  end

endmodule

// File: rtl/rgmii_rx_path.sv
module rgmii_rx_path #(
  parameter int BYTE_W = 8,
  localparam int NIB_W = BYTE_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nibble_mode,
  input  logic [NIB_W-1:0]  rxd_rise,
  input  logic [NIB_W-1:0]  rxd_fall,
  input  logic              rxctl_rise,
  input  logic              rxctl_fall,
  output logic              lo_pending,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_err
);

  logic             phase_q;
  logic [NIB_W-1:0] lo_q;
  logic             lo_err_q;
  logic             nib_err;

  always_comb begin
    nib_err    = rxctl_rise ^ rxctl_fall;
    lo_pending = phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= 1'b0;
      lo_q     <= '0;
      lo_err_q <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_err   <= 1'b0;
    end else if (!rxctl_rise) begin
      // Valid low: no byte, and any unpaired nibble is dropped.
      phase_q  <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_err   <= 1'b0;
    end else if (!nibble_mode) begin
      phase_q  <= 1'b0;
      rx_valid <= 1'b1;
      rx_data  <= {rxd_fall, rxd_rise};
      rx_err   <= nib_err;
    end else if (!phase_q) begin
      phase_q  <= 1'b1;
      lo_q     <= rxd_rise;
      lo_err_q <= nib_err;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_err   <= 1'b0;
    end else begin
      phase_q  <= 1'b0;
      rx_valid <= 1'b1;
      rx_data  <= {rxd_rise, lo_q};
      rx_err   <= lo_err_q | nib_err;
    end
  end

endmodule

// File: rtl/gmii_rgmii_bridge.sv
module gmii_rgmii_bridge
  import gmii_rgmii_pkg::*;
#(
  parameter int     BYTE_W      = 8,
  parameter speed_e RESET_SPEED = SPD_1000,
  localparam int    NIB_W       = BYTE_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        speed_sel,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_err,
  output logic [NIB_W-1:0]  rgmii_txd_rise,
  output logic [NIB_W-1:0]  rgmii_txd_fall,
  output logic              rgmii_txctl_rise,
  output logic              rgmii_txctl_fall,
  input  logic [NIB_W-1:0]  rgmii_rxd_rise,
  input  logic [NIB_W-1:0]  rgmii_rxd_fall,
  input  logic              rgmii_rxctl_rise,
  input  logic              rgmii_rxctl_fall,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_err
);

  logic nib_mode;
  logic tx_hi_pend;
  logic rx_lo_pend;
  logic link_idle;

  assign link_idle = !(tx_valid || tx_hi_pend || rgmii_rxctl_rise || rx_lo_pend);

  rgmii_speed_ctl #(
    .RESET_SPEED (RESET_SPEED)
  ) i_speed (
    .clk         (clk),
    .rst_n       (rst_n),
    .speed_sel   (speed_sel),
    .link_idle   (link_idle),
    .nibble_mode (nib_mode)
  );

  rgmii_tx_path #(
    .BYTE_W (BYTE_W)
  ) i_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .nibble_mode (nib_mode),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .tx_err      (tx_err),
    .hi_pending  (tx_hi_pend),
    .txd_rise    (rgmii_txd_rise),
    .txd_fall    (rgmii_txd_fall),
    .txctl_rise  (rgmii_txctl_rise),
    .txctl_fall  (rgmii_txctl_fall)
  );

  rgmii_rx_path #(
    .BYTE_W (BYTE_W)
  ) i_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .nibble_mode (nib_mode),
    .rxd_rise    (rgmii_rxd_rise),
    .rxd_fall    (rgmii_rxd_fall),
    .rxctl_rise  (rgmii_rxctl_rise),
    .rxctl_fall  (rgmii_rxctl_fall),
    .lo_pending  (rx_lo_pend),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .rx_err      (rx_err)
  );

endmodule

// File: rtl/gmii_rgmii_bridge_chk.sv
module gmii_rgmii_bridge_chk #(
  parameter int BYTE_W = 8,
  localparam int NIB_W = BYTE_W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nib_mode,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [BYTE_W-1:0] tx_data,
  input logic [NIB_W-1:0]  rgmii_txd_rise,
  input logic [NIB_W-1:0]  rgmii_txd_fall,
  input logic              rgmii_txctl_rise,
  input logic              rgmii_txctl_fall,
  input logic [NIB_W-1:0]  rgmii_rxd_rise,
  input logic [NIB_W-1:0]  rgmii_rxd_fall,
  input logic              rgmii_rxctl_rise,
  input logic              rx_valid,
  input logic [BYTE_W-1:0] rx_data,
  input logic              rx_err
);

  // R3
  tx_idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rgmii_txctl_rise |-> !rgmii_txctl_fall);

  // R2
  gig_tx_nibbles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !nib_mode) |=> (rgmii_txctl_rise &&
      rgmii_txd_rise == $past(tx_data[NIB_W-1:0]) &&
      rgmii_txd_fall == $past(tx_data[BYTE_W-1:NIB_W])));

  // R4
  gig_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nib_mode |-> tx_ready);

  // R5
  nib_second_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && nib_mode) |=> !tx_ready);

  // R6
  gig_rx_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rgmii_rxctl_rise && !nib_mode) |=>
      (rx_valid && rx_data == $past({rgmii_rxd_fall, rgmii_rxd_rise})));

  // R7
  rx_err_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> rx_valid);

  // R10
  speed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> nib_mode == $past(nib_mode));

endmodule

bind gmii_rgmii_bridge gmii_rgmii_bridge_chk #(.BYTE_W(BYTE_W)) i_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .nib_mode         (nib_mode),
  .tx_valid         (tx_valid),
  .tx_ready         (tx_ready),
  .tx_data          (tx_data),
  .rgmii_txd_rise   (rgmii_txd_rise),
  .rgmii_txd_fall   (rgmii_txd_fall),
  .rgmii_txctl_rise (rgmii_txctl_rise),
  .rgmii_txctl_fall (rgmii_txctl_fall),
  .rgmii_rxd_rise   (rgmii_rxd_rise),
  .rgmii_rxd_fall   (rgmii_rxd_fall),
  .rgmii_rxctl_rise (rgmii_rxctl_rise),
  .rx_valid         (rx_valid),
  .rx_data          (rx_data),
  .rx_err           (rx_err)
);

// File: tb/test_gmii_rgmii_bridge.sv
`timescale 1ns/1ps
module test_gmii_rgmii_bridge;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] speed_sel;
  logic       tx_valid;
  wire        tx_ready;
  logic [7:0] tx_data;
  logic       tx_err;
  wire  [3:0] txd_r, txd_f;
  wire        txc_r, txc_f;
  logic [3:0] rxd_r, rxd_f;
  logic       rxc_r, rxc_f;
  wire        rx_valid;
  wire  [7:0] rx_data;
  wire        rx_err;

  int    checks = 0;
  int    fails  = 0;
  string ctx    = "R1 reset";

  // Bench model state, built from the requirements.
  logic       m_nib, m_tph, m_terr, m_rph, m_rerr;
  logic [3:0] m_thi, m_rlo;

  always #2.5 clk = ~clk;

  gmii_rgmii_bridge i_gmii_rgmii_bridge (
    .clk              (clk),
    .rst_n            (rst_n),
    .speed_sel        (speed_sel),
    .tx_valid         (tx_valid),
    .tx_ready         (tx_ready),
    .tx_data          (tx_data),
    .tx_err           (tx_err),
    .rgmii_txd_rise   (txd_r),
    .rgmii_txd_fall   (txd_f),
    .rgmii_txctl_rise (txc_r),
    .rgmii_txctl_fall (txc_f),
    .rgmii_rxd_rise   (rxd_r),
    .rgmii_rxd_fall   (rxd_f),
    .rgmii_rxctl_rise (rxc_r),
    .rgmii_rxctl_fall (rxc_f),
    .rx_valid         (rx_valid),
    .rx_data          (rx_data),
    .rx_err           (rx_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s | %s: actual=%0h expected=%0h", ctx, tag, act, exp);
    end
  endtask

  // Drives one clock of stimulus (called at a falling edge) and checks the result.
  task automatic run_cycle(input logic tv, input logic [7:0] td, input logic te,
                           input logic [1:0] ss, input logic [3:0] rr, input logic [3:0] rf,
                           input logic cr, input logic cf);
    logic nib, e_rdy, e_cr, e_cf, e_v, e_e, idle;
    logic [3:0] e_tr, e_tf;
    logic [7:0] e_d;
    tx_valid = tv; tx_data = td; tx_err = te; speed_sel = ss;
    rxd_r = rr; rxd_f = rf; rxc_r = cr; rxc_f = cf;
    nib   = m_nib;
    e_rdy = nib ? !m_tph : 1'b1;
    #1;
    chk(nib ? "R5 tx_ready nibble" : "R4 tx_ready gigabit", {31'd0, tx_ready}, {31'd0, e_rdy});
    e_tr = 4'h0; e_tf = 4'h0; e_cr = 1'b0; e_cf = 1'b0;
    if (!nib) begin
      if (tv) begin e_tr = td[3:0]; e_tf = td[7:4]; e_cr = 1'b1; e_cf = !te; end
    end else if (m_tph) begin
      e_tr = m_thi; e_tf = m_thi; e_cr = 1'b1; e_cf = !m_terr;
    end else if (tv) begin
      e_tr = td[3:0]; e_tf = td[3:0]; e_cr = 1'b1; e_cf = !te;
    end
    e_v = 1'b0; e_d = 8'h00; e_e = 1'b0;
    if (!nib) begin
      if (cr) begin e_v = 1'b1; e_d = {rf, rr}; e_e = cr ^ cf; end
    end else if (cr && m_rph) begin
      e_v = 1'b1; e_d = {rr, m_rlo}; e_e = m_rerr | (cr ^ cf);
    end
    idle = !tv && !m_tph && !cr && !m_rph;
    if (nib && !m_tph && tv) begin m_thi = td[7:4]; m_terr = te; end
    m_tph = nib && !m_tph && tv;
    if (nib && cr && !m_rph) begin m_rlo = rr; m_rerr = cr ^ cf; end
    m_rph = nib && cr && !m_rph;
    if (idle) m_nib = !ss[1];
    @(negedge clk);
    chk("R3 tx control halves", {30'd0, txc_r, txc_f}, {30'd0, e_cr, e_cf});
    chk(nib ? "R5 tx nibbles" : "R2 tx nibbles", {24'd0, txd_r, txd_f}, {24'd0, e_tr, e_tf});
    chk(nib ? "R8 rx_valid" : "R6 rx_valid", {31'd0, rx_valid}, {31'd0, e_v});
    if (e_v) begin
      chk(nib ? "R8 rx_data" : "R6 rx_data", {24'd0, rx_data}, {24'd0, e_d});
      chk("R7 rx_err with byte", {31'd0, rx_err}, {31'd0, e_e});
    end else begin
      chk("R7 rx_err idle", {31'd0, rx_err}, 32'd0);
    end
  endtask

  task automatic rand_cycle(input logic [1:0] ss);
    logic [31:0] r1, r2;
    logic cr;
    r1 = $urandom;
    r2 = $urandom;
    cr = (r2[3:2] != 2'b00);
    run_cycle(r1[3:0] < 4'd11, r1[15:8], r1[7:4] == 4'd0, ss,
              r2[15:12], r2[19:16], cr, cr ^ (r2[7:4] == 4'd0));
  endtask

  task automatic idle_cycle(input logic [1:0] ss);
    run_cycle(1'b0, 8'h00, 1'b0, ss, 4'h0, 4'h0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    m_nib = 1'b0; m_tph = 1'b0; m_terr = 1'b0; m_rph = 1'b0; m_rerr = 1'b0;
    m_thi = 4'h0; m_rlo = 4'h0;
    rst_n = 1'b0; speed_sel = 2'b10; tx_valid = 1'b0; tx_data = 8'h00; tx_err = 1'b0;
    rxd_r = 4'h0; rxd_f = 4'h0; rxc_r = 1'b0; rxc_f = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tx control in reset", {30'd0, txc_r, txc_f}, 32'd0);
    chk("R1 tx nibbles in reset", {24'd0, txd_r, txd_f}, 32'd0);
    chk("R1 rx_valid in reset", {31'd0, rx_valid}, 32'd0);
    chk("R1 tx_ready gigabit after reset", {31'd0, tx_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed gigabit corners: good byte, errored byte, idle
    ctx = "R2 R3 gigabit directed";
    run_cycle(1'b1, 8'hA5, 1'b0, 2'b10, 4'h3, 4'hC, 1'b1, 1'b1);
    run_cycle(1'b1, 8'h0F, 1'b1, 2'b10, 4'h9, 4'h6, 1'b1, 1'b0);
    run_cycle(1'b0, 8'hFF, 1'b1, 2'b10, 4'hF, 4'hF, 1'b0, 1'b1);
    idle_cycle(2'b10);

    // R10: request 100 Mbit/s while a frame is sent; must be ignored
    ctx = "R10 rate request during frame";
    for (int i = 0; i < 20; i++) begin
      r = $urandom;
      run_cycle(1'b1, r[7:0], 1'b0, 2'b01, 4'h0, 4'h0, 1'b0, 1'b0);
    end
    chk("R10 still gigabit after frame", {31'd0, tx_ready}, 32'd1);
    idle_cycle(2'b01);
    run_cycle(1'b1, 8'h3C, 1'b0, 2'b01, 4'h0, 4'h0, 1'b0, 1'b0);
    chk("R10 nibble mode after idle edge", {31'd0, tx_ready}, 32'd0);
    run_cycle(1'b1, 8'h77, 1'b1, 2'b01, 4'h0, 4'h0, 1'b0, 1'b0);
    idle_cycle(2'b01);
    idle_cycle(2'b01);

    // R9: odd nibble count drops the unpaired nibble
    ctx = "R9 partial nibble";
    run_cycle(1'b0, 8'h00, 1'b0, 2'b01, 4'h5, 4'h5, 1'b1, 1'b1);
    run_cycle(1'b0, 8'h00, 1'b0, 2'b01, 4'hA, 4'hA, 1'b1, 1'b1);
    run_cycle(1'b0, 8'h00, 1'b0, 2'b01, 4'h3, 4'h3, 1'b1, 1'b0);
    run_cycle(1'b0, 8'h00, 1'b0, 2'b01, 4'h0, 4'h0, 1'b0, 1'b0);
    run_cycle(1'b0, 8'h00, 1'b0, 2'b01, 4'h7, 4'h7, 1'b1, 1'b1);
    run_cycle(1'b0, 8'h00, 1'b0, 2'b01, 4'h1, 4'h1, 1'b1, 1'b1);
    chk("R9 byte after dropped nibble", {24'd0, rx_data}, 32'h17);
    idle_cycle(2'b01);

    // R12: both directions at 100 Mbit/s
    ctx = "R12 both directions 100M";
    for (int i = 0; i < 400; i++) rand_cycle(2'b01);
    for (int i = 0; i < 4; i++) idle_cycle(2'b00);

    // R11: 10 Mbit/s behaves as 100 Mbit/s
    ctx = "R11 10M random";
    for (int i = 0; i < 300; i++) rand_cycle(2'b00);

    // R10 random: rate requests change at random points
    ctx = "R10 random rate changes";
    for (int i = 0; i < 600; i++) begin
      r = $urandom;
      rand_cycle(r[4:0] == 5'd0 ? r[9:8] : speed_sel);
    end
    for (int i = 0; i < 4; i++) idle_cycle(2'b10);
    ctx = "R12 both directions gigabit";
    for (int i = 0; i < 300; i++) rand_cycle(2'b10);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule